// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer whose write side and read side run on separate clocks. The two clocks may come from one source or run at unrelated rates. Each side has its own enable: one word of 18 bits is taken in per write-clock edge while the write enable is high, and one word is given out per read-clock edge while the read enable is high. A single active-low reset clears both sides. The depth is a parameter and must be a power of two, so a small buffer can be used in simulation and a large one on the chip.

The block has five status outputs: empty and full, a half-full indication, and two threshold flags. The almost-empty flag is set when the stored count is at or below a programmable offset. The almost-full flag is set when the count is at or above the depth minus a second offset. Both offsets start at 127 and can be rewritten through a small load port on the write clock. A mode input chooses how the threshold flags are produced. In the registered mode, each flag is produced in its own clock domain. In the direct mode, each flag is a comparator on the two raw pointers. A retransmit input moves the read pointer back to the first storage location, so that data already read can be read again.

Top module: `prog_flag_fifo`

## Requirements
- R1: While reset is low and just after it is released, empty=1, almost_empty=1, full=0, half_full=0, almost_full=0 and rd_data=0.
- R2: Words leave the read port in the order they entered the write port. Each enabled read edge gives one word and each accepted write advances the write pointer by exactly one.
- R3: Once the crossing delay has passed, full is 1 when DEPTH words are stored and empty is 1 when none are stored. Both are 0 otherwise.
- R4: rd_data is registered. It changes only after a read-clock edge at which rd_en=1 and empty=0, and holds at all other times. The first word written into an empty buffer appears after the first read edge that follows empty going low.
- R5: A write while full and a read while empty are ignored. Neither moves a pointer, neither changes rd_data, and neither alters the stored data.
- R6: half_full is 1 when the count is DEPTH/2+1 or more, and 0 when the count is DEPTH/2 or fewer.
- R7: almost_empty is 1 when count <= AE offset. almost_full is 1 when count >= DEPTH - AF offset. With DEPTH=256 and both offsets at 127, the flags switch between counts 127/128 and 128/129. In the registered mode, empty implies almost_empty and full implies almost_full.
- R8: A write-clock edge with ofs_load=1 stores ofs_val into the AE offset when ofs_sel=0, or into the AF offset when ofs_sel=1.
- R9: A read-clock edge with retx=1 sets the read pointer to storage location 0. The following reads replay the data from the first word written after reset. This is valid while no more than DEPTH words have been written since reset.
- R10: With flag_sync=1, almost_empty is updated only on read-clock edges and almost_full only on write-clock edges. If the read clock is stopped, almost_empty keeps its old value while writes proceed.
- R11: With flag_sync=0, almost_empty and almost_full follow the difference of the raw write and read pointers. They respond to writes even while the read clock is stopped.
- R12: Reset restores both offsets to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Common asynchronous reset, active low |
| wr_en | input | 1 | Write enable, sampled on wclk |
| wr_data | input | DATA_W | Word to be written |
| rd_en | input | 1 | Read enable, sampled on rclk |
| rd_data | output | DATA_W | Registered read word |
| retx | input | 1 | Retransmit: rewind read pointer to location 0 (rclk) |
| flag_sync | input | 1 | 1 = registered threshold flags, 0 = direct pointer comparison |
| ofs_load | input | 1 | Offset load strobe (wclk) |
| ofs_sel | input | 1 | 0 = almost-empty offset, 1 = almost-full offset |
| ofs_val | input | $clog2(DEPTH) | Offset value to load |
| empty | output | 1 | No words stored (read domain) |
| almost_empty | output | 1 | Count at or below the almost-empty offset |
| half_full | output | 1 | Count above half the depth (write domain) |
| almost_full | output | 1 | Count at or above depth minus the almost-full offset |
| full | output | 1 | DEPTH words stored (write domain) |

## Verification
The bound checker enforces the following on every edge of its own clock:
- a write at full or a read at empty leaves the pointers and the output word unchanged;
- rd_data holds whenever no read is requested;
- each accepted write steps the write pointer by one;
- a retransmit leaves the read pointer at zero;
- full implies half-full, and in the registered mode full implies almost-full and empty implies almost-empty.

Only the directed scenarios can show the rest. These cover data order and integrity across a full fill, the exact threshold counts for half-full and both offsets before and after a load, the replay after retransmit, and the difference between the two flag modes when the read clock is stopped.

// File: rtl/pff_pkg.sv
`timescale 1ns/1ps
package pff_pkg;
   typedef enum logic {
      OFS_AE = 1'b0,
      OFS_AF = 1'b1
   } ofs_sel_e;

   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/pff_sync.sv
`timescale 1ns/1ps
module pff_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pff_mem.sv
`timescale 1ns/1ps
module pff_mem #(
   parameter int DATA_W = 18,
   parameter int AW     = 8
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS = 1 << AW;

   logic [DATA_W-1:0] store [WORDS];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= store[raddr];
   end
endmodule

// File: rtl/pff_wr_ctl.sv
`timescale 1ns/1ps
module pff_wr_ctl #(
   parameter int AW     = 8,
   parameter int STAGES = 2,
   localparam int PW    = AW + 1
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] r_gray,
   input  logic [AW-1:0] af_ofs,
   output logic [PW-1:0] w_bin,
   output logic [PW-1:0] w_gray,
   output logic          w_fire,
   output logic          full,
   output logic          half_full,
   output logic          af_sync
);
   localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};
   localparam logic [PW-1:0] HALF_P  = {2'b01, {(AW-1){1'b0}}};

   logic [PW-1:0] r_gray_s, r_bin_s, w_bin_nx, cnt_nx;

   pff_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
      .clk(wclk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s)
   );

   always_comb begin
      for (int i = 0; i < PW; i++) r_bin_s[i] = ^(r_gray_s >> i);
   end

   assign w_fire   = wr_en & ~full;
   assign w_bin_nx = w_bin + {{AW{1'b0}}, w_fire};
   assign cnt_nx   = w_bin_nx - r_bin_s;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         w_bin     <= '0;
         w_gray    <= '0;
         full      <= 1'b0;
         half_full <= 1'b0;
         af_sync   <= 1'b0;
      end else begin
         w_bin     <= w_bin_nx;
         w_gray    <= w_bin_nx ^ (w_bin_nx >> 1);
         full      <= (cnt_nx == DEPTH_P);
         half_full <= (cnt_nx > HALF_P);
         af_sync   <= (cnt_nx >= (DEPTH_P - {1'b0, af_ofs}));
      end
   end
endmodule

// File: rtl/pff_rd_ctl.sv
`timescale 1ns/1ps
module pff_rd_ctl #(
   parameter int AW     = 8,
   parameter int STAGES = 2,
   localparam int PW    = AW + 1
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          retx,
   input  logic [PW-1:0] w_gray,
   input  logic [AW-1:0] ae_ofs,
   output logic [PW-1:0] r_bin,
   output logic [PW-1:0] r_gray,
   output logic          r_fire,
   output logic          empty,
   output logic          ae_sync
);
   logic [PW-1:0] w_gray_s, w_bin_s, r_bin_nx, cnt_nx;

   pff_sync #(.W(PW), .STAGES(STAGES)) u_wsync (
      .clk(rclk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s)
   );

   always_comb begin
      for (int i = 0; i < PW; i++) w_bin_s[i] = ^(w_gray_s >> i);
   end

   assign r_fire   = rd_en & ~empty & ~retx;
   assign r_bin_nx = retx ? '0 : (r_bin + {{AW{1'b0}}, r_fire});
   assign cnt_nx   = w_bin_s - r_bin_nx;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         r_bin   <= '0;
         r_gray  <= '0;
         empty   <= 1'b1;
         ae_sync <= 1'b1;
      end else begin
         r_bin   <= r_bin_nx;
         r_gray  <= r_bin_nx ^ (r_bin_nx >> 1);
         empty   <= (cnt_nx == '0);
         ae_sync <= (cnt_nx <= {1'b0, ae_ofs});
      end
   end
endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo #(
   parameter int DATA_W      = 18,
   parameter int DEPTH       = 256,
   parameter int DEF_OFS     = 127,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              retx,
   input  logic              flag_sync,
   input  logic              ofs_load,
   input  logic              ofs_sel,
   input  logic [AW-1:0]     ofs_val,
   output logic              empty,
   output logic              almost_empty,
   output logic              half_full,
   output logic              almost_full,
   output logic              full
);
   import pff_pkg::*;

   localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};

   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "DEPTH must be a power of two of at least 4");
      assert (DEF_OFS >= 0 && DEF_OFS < DEPTH)
         else $fatal(1, "DEF_OFS must lie inside the depth");
      assert (SYNC_STAGES >= MIN_SYNC_STAGES)
         else $fatal(1, "SYNC_STAGES too small");
      assert (DATA_W > 0)
         else $fatal(1, "DATA_W must be positive");
   end

   logic [AW-1:0] ae_ofs, af_ofs;
   logic [PW-1:0] w_bin, w_gray, r_bin, r_gray, cnt_direct;
   logic          w_fire, r_fire, ae_sync, af_sync, ae_direct, af_direct;
   ofs_sel_e      sel;

   assign sel = ofs_sel_e'(ofs_sel);

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         ae_ofs <= AW'(DEF_OFS);
         af_ofs <= AW'(DEF_OFS);
      end else if (ofs_load) begin
         if (sel == OFS_AE) ae_ofs <= ofs_val;
         else               af_ofs <= ofs_val;
      end
   end

   pff_wr_ctl #(.AW(AW), .STAGES(SYNC_STAGES)) u_wr (
      .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .r_gray(r_gray),
      .af_ofs(af_ofs), .w_bin(w_bin), .w_gray(w_gray), .w_fire(w_fire),
      .full(full), .half_full(half_full), .af_sync(af_sync)
   );

   pff_rd_ctl #(.AW(AW), .STAGES(SYNC_STAGES)) u_rd (
      .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .retx(retx),
      .w_gray(w_gray), .ae_ofs(ae_ofs), .r_bin(r_bin), .r_gray(r_gray),
      .r_fire(r_fire), .empty(empty), .ae_sync(ae_sync)
   );

   pff_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
      .wclk(wclk), .we(w_fire), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
      .rclk(rclk), .rst_n(rst_n), .re(r_fire), .raddr(r_bin[AW-1:0]),
      .rdata(rd_data)
   );

   assign cnt_direct = w_bin - r_bin;
   assign ae_direct  = (cnt_direct <= {1'b0, ae_ofs});
   assign af_direct  = (cnt_direct >= (DEPTH_P - {1'b0, af_ofs}));

   assign almost_empty = flag_sync ? ae_sync : ae_direct;
   assign almost_full  = flag_sync ? af_sync : af_direct;
endmodule

// File: rtl/pff_chk.sv
`timescale 1ns/1ps
module pff_chk #(
   parameter int DATA_W = 18,
   parameter int PW     = 9
) (
   input logic              wclk,
   input logic              rclk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              retx,
   input logic              flag_sync,
   input logic              full,
   input logic              empty,
   input logic              half_full,
   input logic              almost_full,
   input logic              almost_empty,
   input logic [DATA_W-1:0] rd_data,
   input logic [PW-1:0]     w_bin,
   input logic [PW-1:0]     r_bin
);
   AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
      (full && wr_en) |=> $stable(w_bin)); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
      (empty && rd_en && !retx) |=> ($stable(r_bin) && $stable(rd_data))); // R5
   AST_DATA_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data)); // R4
   AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_en && !full) |=> (w_bin == $past(w_bin) + 1'b1)); // R2
   AST_RETX_REWIND: assert property (@(posedge rclk) disable iff (!rst_n)
      retx |=> (r_bin == '0)); // R9
   AST_FULL_HALF: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> half_full); // R6
   AST_FULL_ALMOST: assert property (@(posedge wclk) disable iff (!rst_n)
      (flag_sync && full) |-> almost_full); // R7
   AST_EMPTY_ALMOST: assert property (@(posedge rclk) disable iff (!rst_n)
      (flag_sync && empty) |-> almost_empty); // R7
endmodule

bind prog_flag_fifo pff_chk #(.DATA_W(DATA_W), .PW(PW)) u_chk (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
   .retx(retx), .flag_sync(flag_sync), .full(full), .empty(empty),
   .half_full(half_full), .almost_full(almost_full),
   .almost_empty(almost_empty), .rd_data(rd_data), .w_bin(w_bin), .r_bin(r_bin)
);

// File: tb/tb_prog_flag_fifo.sv
`timescale 1ns/1ps
module tb_prog_flag_fifo;
   localparam int DW    = 18;
   localparam int DEPTH = 256;
   localparam int AW    = 8;

   logic          wclk = 1'b0, rclk = 1'b0, rclk_run = 1'b1;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0;
   logic          flag_sync = 1'b1, ofs_load = 1'b0, ofs_sel = 1'b0;
   logic [AW-1:0] ofs_val = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          empty, almost_empty, half_full, almost_full, full;
   int            n_chk = 0, n_bad = 0;

   prog_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .retx(retx), .flag_sync(flag_sync),
      .ofs_load(ofs_load), .ofs_sel(ofs_sel), .ofs_val(ofs_val),
      .empty(empty), .almost_empty(almost_empty), .half_full(half_full),
      .almost_full(almost_full), .full(full)
   );

   always #10 wclk = ~wclk;
   initial begin
      #7;
      forever begin
         #10;
         if (rclk_run) rclk = ~rclk;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic settle();
      repeat (6) @(negedge wclk);
      repeat (6) @(negedge rclk);
   endtask

   task automatic do_reset();
      rclk_run = 1'b1;
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; retx = 1'b0; ofs_load = 1'b0;
      repeat (3) @(negedge wclk);
      rst_n = 1'b1;
      settle();
   endtask

   task automatic push(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         @(negedge wclk);
         wr_en = 1'b1;
         wr_data = DW'(base + i);
      end
      @(negedge wclk);
      wr_en = 1'b0;
   endtask

   task automatic pop_check(input int n, input int base, input string req);
      @(negedge rclk);
      rd_en = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge rclk);
         if (i == n - 1) rd_en = 1'b0;
         check(req, 32'(rd_data), 32'(DW'(base + i)));
      end
   endtask

   task automatic load_ofs(input logic sel, input int val);
      @(negedge wclk);
      ofs_load = 1'b1; ofs_sel = sel; ofs_val = AW'(val);
      @(negedge wclk);
      ofs_load = 1'b0;
   endtask

   task automatic t_reset_state();
      flag_sync = 1'b1;
      do_reset();
      check("R1 empty", 32'(empty), 1);
      check("R1 almost_empty", 32'(almost_empty), 1);
      check("R1 full", 32'(full), 0);
      check("R1 half_full", 32'(half_full), 0);
      check("R1 almost_full", 32'(almost_full), 0);
      check("R1 rd_data", 32'(rd_data), 0);
   endtask

   task automatic t_order();
      do_reset();
      push(5, 'h100);
      settle();
      check("R3 not empty", 32'(empty), 0);
      pop_check(5, 'h100, "R2 order");
      settle();
      check("R3 empty again", 32'(empty), 1);
   endtask

   task automatic t_first_word();
      do_reset();
      @(negedge wclk); wr_en = 1'b1; wr_data = 'h2A5A5;
      @(negedge wclk); wr_en = 1'b0;
      while (empty) @(negedge rclk);
      check("R4 hold before read", 32'(rd_data), 0);
      rd_en = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
      check("R4 first word", 32'(rd_data), 'h2A5A5);
      @(negedge rclk); rd_en = 1'b1;
      repeat (3) @(negedge rclk);
      rd_en = 1'b0;
      check("R5 read at empty ignored data", 32'(rd_data), 'h2A5A5);
      check("R5 still empty", 32'(empty), 1);
      push(1, 'h15);
      settle();
      pop_check(1, 'h15, "R5 next word after empty read");
   endtask

   task automatic t_fill();
      do_reset();
      push(DEPTH, 0);
      settle();
      check("R3 full", 32'(full), 1);
      check("R6 half_full at full", 32'(half_full), 1);
      check("R7 almost_full at full", 32'(almost_full), 1);
      check("R7 almost_empty at full", 32'(almost_empty), 0);
      push(1, 'h3FFFF);
      settle();
      check("R5 still full", 32'(full), 1);
      pop_check(DEPTH, 0, "R5 data intact after overflow");
      settle();
      check("R5 empty after draining", 32'(empty), 1);
      check("R3 not full", 32'(full), 0);
   endtask

   task automatic t_thresholds();
      do_reset();
      push(127, 0);
      settle();
      check("R7 ae at 127", 32'(almost_empty), 1);
      push(1, 127);
      settle();
      check("R7 ae at 128", 32'(almost_empty), 0);
      check("R6 hf at 128", 32'(half_full), 0);
      check("R7 af at 128", 32'(almost_full), 0);
      push(1, 128);
      settle();
      check("R6 hf at 129", 32'(half_full), 1);
      check("R7 af at 129", 32'(almost_full), 1);
      pop_check(1, 0, "R2 head word");
      settle();
      check("R6 hf back at 128", 32'(half_full), 0);
      check("R7 af back at 128", 32'(almost_full), 0);
   endtask

   task automatic t_program();
      do_reset();
      load_ofs(1'b0, 3);
      load_ofs(1'b1, 10);
      push(3, 0);
      settle();
      check("R8 ae at 3 with ofs 3", 32'(almost_empty), 1);
      push(1, 3);
      settle();
      check("R8 ae at 4 with ofs 3", 32'(almost_empty), 0);
      push(126, 4);
      settle();
      check("R8 af at 130 with ofs 10", 32'(almost_full), 0);
      push(115, 130);
      settle();
      check("R8 af at 245", 32'(almost_full), 0);
      push(1, 245);
      settle();
      check("R8 af at 246", 32'(almost_full), 1);
      do_reset();
      push(4, 0);
      settle();
      check("R12 ae default at 4", 32'(almost_empty), 1);
      push(126, 4);
      settle();
      check("R12 af default at 130", 32'(almost_full), 1);
   endtask

   task automatic t_retransmit();
      do_reset();
      push(6, 'h40);
      settle();
      pop_check(6, 'h40, "R2 before retransmit");
      settle();
      check("R9 empty before retx", 32'(empty), 1);
      @(negedge rclk); retx = 1'b1;
      @(negedge rclk); retx = 1'b0;
      settle();
      check("R9 not empty after retx", 32'(empty), 0);
      pop_check(6, 'h40, "R9 replay");
      settle();
      check("R9 empty after replay", 32'(empty), 1);
   endtask

   task automatic t_sync_mode();
      flag_sync = 1'b1;
      do_reset();
      load_ofs(1'b0, 3);
      settle();
      rclk_run = 1'b0;
      push(4, 0);
      repeat (4) @(negedge wclk);
      check("R10 ae stale without rclk", 32'(almost_empty), 1);
      rclk_run = 1'b1;
      settle();
      check("R10 ae after rclk resumes", 32'(almost_empty), 0);
   endtask

   task automatic t_direct_mode();
      flag_sync = 1'b0;
      do_reset();
      load_ofs(1'b0, 3);
      load_ofs(1'b1, 250);
      settle();
      rclk_run = 1'b0;
      push(3, 0);
      check("R11 ae at 3", 32'(almost_empty), 1);
      check("R11 af at 3", 32'(almost_full), 0);
      push(1, 3);
      check("R11 ae at 4 no rclk", 32'(almost_empty), 0);
      push(2, 4);
      check("R11 af at 6 no rclk", 32'(almost_full), 1);
      rclk_run = 1'b1;
      settle();
      flag_sync = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge wclk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      t_reset_state();
      t_order();
      t_first_word();
      t_fill();
      t_thresholds();
      t_program();
      t_retransmit();
      t_sync_mode();
      t_direct_mode();
      summary();
      $finish;
   end
endmodule